// File: doc/BRIEF.md
# Interrupting Down-Counter

This block is a free-running binary down-counter of parameterised width (32 bits by default). It steps down by one on each cycle where a timebase tick enable is high. Software can load a new count through a write strobe and data bus, and it can read the current count at any time. The count has no reset. It holds its value through hard and soft reset and keeps stepping while reset is applied, so software must give it a starting value.

The block raises an interrupt request when the counter's most significant bit goes from 0 to 1. That edge can come from a decrement that wraps past zero or from a software load. The request is held in a single pending flag, so several edges before service collapse into one interrupt. The flag clears when the core acknowledges that the interrupt was taken. A separate output carries the request to wake-up logic. It is either a level copy of the pending flag or a one-cycle pulse per edge, selected by a parameter.

Top module: `decrementer_irq`

## Requirements
- R1: On a cycle with `tick_en` high and `wr_en` low, the count presented on `count_o` decreases by exactly one at the next rising edge, and 0 wraps to all ones.
- R2: `rst_n` has no effect on the count: ticks and writes applied while `rst_n` is low update the count exactly as they do when it is high.
- R3: A cycle with `wr_en` high replaces the whole count with `wr_data` at the next rising edge; `count_o` always shows the current count, and reading it changes nothing.
- R4: When a decrement turns the count's most significant bit (bit WIDTH-1) from 0 to 1, which happens only when stepping from 0, `irq_pend` is 1 after that edge; a most significant bit that stays 1 or falls raises no request.
- R5: A write whose data has bit WIDTH-1 set, loaded over a count with that bit clear, sets `irq_pend`; a write that keeps the bit at 1 does not.
- R6: `irq_pend` is a single flag. Once set, it stays 1 until acknowledged, whatever further edges occur, and one acknowledge clears it.
- R7: `irq_ack` high while no edge occurs clears `irq_pend` at the next rising edge.
- R8: In the default level mode (`WAKE_MODE` = `WAKE_LEVEL`), `wake_o` equals `irq_pend`. In the pulse mode it is high for one cycle after each edge. In both modes `wake_o` high implies `irq_pend` high.
- R9: When `wr_en` and `tick_en` are both high, the written value is loaded and no decrement is applied in that cycle.
- R10: When `irq_ack` coincides with a new 0-to-1 edge of the most significant bit, `irq_pend` remains 1.
- R11: `rst_n` low at a rising edge clears `irq_pend` and `wake_o` (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the request state only |
| tick_en | input | 1 | Timebase tick; decrements the count when high |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | WIDTH | Value to load |
| count_o | output | WIDTH | Current count (read port) |
| irq_ack | input | 1 | Core has taken the interrupt |
| irq_pend | output | 1 | Pending interrupt request |
| wake_o | output | 1 | Request routed to wake-up logic |

## Verification
The properties assume that `tick_en`, `wr_en`, `wr_data` and `irq_ack` are stable around each rising edge. They also assume that the count has been loaded at least once before its value is compared, because the counter itself starts undefined. The stimulus changes every input only on the falling clock edge. Its first action is a write, made while reset is still asserted, so every later count value follows from known inputs. The acknowledge is driven only at chosen points, including the cycle where it meets a fresh edge. This lets the bench tell a cleared flag from a held one.

// File: rtl/dec_pkg.sv
package dec_pkg;

   typedef enum logic {
      WAKE_LEVEL = 1'b0,
      WAKE_PULSE = 1'b1
   } wake_mode_e;

   // Result of one update step of the count
   typedef struct packed {
      logic upd;       // count register loaded this cycle
      logic old_top;   // top bit before the edge
      logic new_top;   // top bit after the edge
   } top_step_t;

endpackage

// File: rtl/dec_count_core.sv
module dec_count_core #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] cnt_q,
   output dec_pkg::top_step_t step_o
);
   localparam int TOP = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] cnt_d;

   // Load has priority over the decrement
   always_comb begin
      if (wr_en)
         cnt_d = wr_data;
      else if (tick_en)
         cnt_d = cnt_q - ONE;
      else
         cnt_d = cnt_q;
   end

   // The count is deliberately kept out of reset
   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   always_comb begin
      step_o.upd     = wr_en | tick_en;
      step_o.old_top = cnt_q[TOP];
      step_o.new_top = cnt_d[TOP];
   end
endmodule

// File: rtl/dec_edge_pend.sv
module dec_edge_pend (
   input  logic               clk,
   input  logic               rst_n,
   input  dec_pkg::top_step_t step_i,
   input  logic               ack_i,
   output logic               edge_o,
   output logic               pend_q
);
   always_comb begin
      edge_o = step_i.upd & ~step_i.old_top & step_i.new_top;
   end

   // A new edge wins over acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (edge_o)
         pend_q <= 1'b1;
      else if (ack_i)
         pend_q <= 1'b0;
   end
endmodule

// File: rtl/dec_wake_out.sv
module dec_wake_out #(
   parameter dec_pkg::wake_mode_e MODE = dec_pkg::WAKE_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic pend_i,
   output logic wake_o
);
   generate
      if (MODE == dec_pkg::WAKE_LEVEL) begin : g_level
         logic unused_w;
         always_comb begin
            unused_w = clk ^ rst_n ^ edge_i;
            wake_o   = pend_i;
         end
      end else begin : g_pulse
         logic pulse_q;
         logic unused_w;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pulse_q <= 1'b0;
            else
               pulse_q <= edge_i;
         end
         always_comb begin
            unused_w = pend_i;
            wake_o   = pulse_q;
         end
      end
   endgenerate
endmodule

// File: rtl/decrementer_irq.sv
module decrementer_irq #(
   parameter int                  WIDTH     = 32,
   parameter dec_pkg::wake_mode_e WAKE_MODE = dec_pkg::WAKE_LEVEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] count_o,
   input  logic             irq_ack,
   output logic             irq_pend,
   output logic             wake_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("decrementer_irq: WIDTH must be at least 2");
      end
   endgenerate

   dec_pkg::top_step_t step_w;
   logic               edge_w;

   dec_count_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cnt_q   (count_o),
      .step_o  (step_w)
   );

   dec_edge_pend u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_w),
      .ack_i  (irq_ack),
      .edge_o (edge_w),
      .pend_q (irq_pend)
   );

   dec_wake_out #(.MODE(WAKE_MODE)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .edge_i (edge_w),
      .pend_i (irq_pend),
      .wake_o (wake_o)
   );
endmodule

// File: rtl/decrementer_irq_chk.sv
module decrementer_irq_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] count_o,
   input logic             irq_ack,
   input logic             irq_pend,
   input logic             wake_o
);
   localparam int TOP = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic loaded_q = 1'b0;
   always_ff @(posedge clk) begin
      if (wr_en) loaded_q <= 1'b1;
   end

   // R1 / R2: decrement regardless of reset
   p_tick_dec_r1: assert property (@(posedge clk)
      loaded_q && tick_en && !wr_en |=> count_o == $past(count_o) - ONE);

   // R2: idle cycle under reset keeps the count
   p_reset_keeps_r2: assert property (@(posedge clk)
      loaded_q && !rst_n && !tick_en && !wr_en |=> $stable(count_o));

   // R3 / R9: load replaces the count, even with a tick
   p_load_r3: assert property (@(posedge clk)
      wr_en |=> count_o == $past(wr_data));

   // R4: wrap past zero raises the request
   p_wrap_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q && tick_en && !wr_en && count_o == '0 |=> irq_pend);

   // R5: load that sets the top bit raises the request
   p_load_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q && wr_en && wr_data[TOP] && !count_o[TOP] |=> irq_pend);

   // R6: held until acknowledged
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend && !irq_ack |=> irq_pend);

   // R7: acknowledge without a new edge clears
   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q && irq_ack
      && !(wr_en && wr_data[TOP] && !count_o[TOP])
      && !(tick_en && !wr_en && count_o == '0)
      |=> !irq_pend);

   // R8: wake implies a pending request
   p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> irq_pend);

   // R11: reset clears request state
   p_reset_clr_r11: assert property (@(posedge clk)
      !rst_n |=> !irq_pend && !wake_o);
endmodule

bind decrementer_irq decrementer_irq_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .count_o  (count_o),
   .irq_ack  (irq_ack),
   .irq_pend (irq_pend),
   .wake_o   (wake_o)
);

// File: tb/tb_decrementer_irq.sv
module tb_decrementer_irq;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   typedef struct {
      logic [W-1:0] cnt;
      logic         pend;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick_en = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         irq_ack = 1'b0;
   logic [W-1:0] count_o;
   logic         irq_pend;
   logic         wake_o;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t q[$];

   logic [W-1:0] m_cnt = '0;
   logic         m_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   decrementer_irq #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_data(wr_data), .count_o(count_o), .irq_ack(irq_ack),
      .irq_pend(irq_pend), .wake_o(wake_o)
   );

   // Monitor: compares one item per cycle, just after the edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_cmp++;
         if (count_o !== e.cnt) begin
            n_bad++;
            $display("FAIL %s count: actual %h expected %h", e.tag, count_o, e.cnt);
         end
         if (irq_pend !== e.pend) begin
            n_bad++;
            $display("FAIL %s irq_pend: actual %b expected %b", e.tag, irq_pend, e.pend);
         end
         if (wake_o !== e.pend) begin
            n_bad++;
            $display("FAIL R8 (%s) wake_o: actual %b expected %b", e.tag, wake_o, e.pend);
         end
      end
   end

   // Driver: applies one cycle of stimulus and queues the expected result
   task automatic step(input logic r, input logic w, input logic [W-1:0] d,
                       input logic t, input logic a, input string tag);
      logic [W-1:0] nxt;
      logic         ev;
      exp_t         e;
      @(negedge clk);
      rst_n = r; wr_en = w; wr_data = d; tick_en = t; irq_ack = a;
      nxt = w ? d : (t ? m_cnt - 1 : m_cnt);
      ev  = (w | t) & ~m_cnt[W-1] & nxt[W-1];
      if (!r)      m_pend = 1'b0;
      else if (ev) m_pend = 1'b1;
      else if (a)  m_pend = 1'b0;
      m_cnt = nxt;
      e.cnt = m_cnt; e.pend = m_pend; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      step(0, 1, 32'h0000_0003, 0, 0, "R2 R11 load in reset");
      step(0, 0, '0, 1, 0, "R2 tick in reset");
      step(0, 0, '0, 1, 0, "R2 tick in reset");
      step(1, 0, '0, 0, 0, "R11 idle after reset");
      step(1, 0, '0, 1, 0, "R1 tick to zero");
      step(1, 0, '0, 1, 0, "R1 R4 wrap raises request");
      step(1, 0, '0, 1, 0, "R4 R6 top stays set, held");
      step(1, 1, 32'h0000_0005, 1, 0, "R9 load beats tick");
      step(1, 1, 32'h8000_0000, 0, 0, "R6 second edge collapses");
      step(1, 0, '0, 0, 1, "R7 ack clears");
      step(1, 1, 32'h7FFF_FFFF, 0, 0, "R4 falling top no request");
      step(1, 1, 32'h8000_0010, 0, 0, "R5 load sets top");
      step(1, 1, 32'h9000_0000, 0, 1, "R5 R7 top kept, ack clears");
      step(1, 1, 32'hA000_0000, 0, 0, "R5 top stays set no request");
      step(1, 0, '0, 0, 0, "R3 read does not disturb");
      step(1, 1, 32'h0000_0000, 0, 0, "R3 load zero");
      step(1, 0, '0, 1, 1, "R10 ack meets edge");
      step(1, 0, '0, 1, 0, "R1 R6 held while counting");
      step(0, 0, '0, 1, 0, "R11 R2 reset clears, count runs");
      step(1, 0, '0, 0, 0, "R2 idle");
      for (int i = 0; i < 6; i++) step(1, 0, '0, 1, 0, "R1 run");
      step(1, 0, '0, 0, 0, "R3 final");
      @(negedge clk);
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule